// File: doc/BRIEF.md
# Reconfigurable Modular Butterfly, q = 3329

This block is one pipelined butterfly for number-theoretic transforms over the prime q = 3329. Three 12-bit operands enter each cycle: u, v and a twiddle w. A 2-bit mode picks the role of the butterfly. In the forward role it forms u plus and minus the twiddled v. In the inverse role it forms the sum of u and v, and the twiddled difference (v − u)·w. Computing v − u instead of u − v lets the inverse transform read the forward twiddle table in reverse order. The third role passes u and v through untouched. It serves the first butterfly row of the last layer when a transform has an odd number of layers.

There is a single modular multiplier. Its 24-bit product goes through a shift-and-add reduction that needs no multiplier. That reduction returns 169·C mod q instead of C mod q. Callers therefore store their twiddles already multiplied by 169⁻¹ mod q, which cancels the extra factor. Every role takes four cycles, so a transform controller can change the mode on every cycle without gaps. A valid bit travels beside the data.

Top module: `bfly_core`

## Requirements
- R1: With mode_i = 0 (forward), x_o = (u + 169·v·w) mod 3329 and y_o = (u − 169·v·w) mod 3329.
- R2: With mode_i = 1 (inverse), x_o = (u + v) mod 3329 and y_o = (169·(v − u)·w) mod 3329.
- R3: With mode_i = 2 (bypass), x_o = u and y_o = v.
- R4: mode_i = 3 behaves exactly like mode_i = 2.
- R5: Operands sampled at a rising edge with valid_i high appear on x_o and y_o, with valid_o high, after the fourth rising edge counting that one. This holds in every mode, and the mode may change on every cycle.
- R6: While u and v are below 3329, x_o and y_o are always below 3329 when valid_o is high.
- R7: While rst_n is low, valid_o, x_o and y_o are all zero.
- R8: The twiddle may take any 12-bit value, including 3329 to 4095. The product is still fully reduced, so R1 and R2 hold with w taken as its integer value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands on this cycle are meaningful |
| mode_i | input | 2 | 0 forward, 1 inverse, 2 and 3 bypass |
| u_i | input | 12 | First operand, below 3329 |
| v_i | input | 12 | Second operand, below 3329 |
| w_i | input | 12 | Twiddle, pre-scaled by 169⁻¹ mod 3329 |
| valid_o | output | 1 | Outputs carry a result |
| x_o | output | 12 | Upper butterfly output |
| y_o | output | 12 | Lower butterfly output |

## Verification
The extreme operands 0 and 3328, and a twiddle of 4095, drive each correction branch of the adder, the subtractors and the reduction to its limit. Running the forward and inverse roles on the same operands separates them through the sign of the twiddled difference. Bypass operands are chosen so that any arithmetic on them would change the result. Long random runs change the mode on every cycle and leave gaps in valid_i. These runs show whether each result stays bound to its own mode and arrives exactly four cycles later. Twiddles drawn over the full 12-bit range show whether the reduction stays exact beyond q.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
    localparam int DW = 12;
    localparam int Q  = 3329;
    localparam int KF = 13;
    localparam int MS = 8;
    localparam int PW = 2 * DW;

    typedef logic [DW-1:0] coef_t;

    typedef enum logic [1:0] {
        BF_CT   = 2'd0,
        BF_GS   = 2'd1,
        BF_PASS = 2'd2,
        BF_ALT  = 2'd3
    } bf_mode_e;

    typedef struct packed {
        logic     vld;
        bf_mode_e mode;
        coef_t    u;
        coef_t    v;
        coef_t    w;
        coef_t    op;
    } st1_t;

    typedef struct packed {
        logic          vld;
        bf_mode_e      mode;
        coef_t         u;
        coef_t         v;
        logic [PW-1:0] prod;
    } st2_t;

    typedef struct packed {
        logic     vld;
        bf_mode_e mode;
        coef_t    u;
        coef_t    v;
        coef_t    t;
    } st3_t;

    typedef struct packed {
        logic  vld;
        coef_t x;
        coef_t y;
    } st4_t;

    typedef struct packed {
        st1_t s1;
        st2_t s2;
        st3_t s3;
        st4_t s4;
    } pipe_t;
endpackage

// File: rtl/bfly_modadd.sv
module bfly_modadd #(
    parameter int DW = 12,
    parameter int Q  = 3329
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] s_o
);
    localparam int SW = DW + 1;
    logic [SW-1:0] sum;

    always_comb begin
        sum = {1'b0, a_i} + {1'b0, b_i};
        if (sum >= SW'(Q)) s_o = DW'(sum - SW'(Q));
        else               s_o = DW'(sum);
    end
endmodule

// File: rtl/bfly_modsub.sv
module bfly_modsub #(
    parameter int DW = 12,
    parameter int Q  = 3329
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] d_o
);
    localparam int SW = DW + 1;
    logic [SW-1:0] dif;

    always_comb begin
        dif = {1'b0, a_i} - {1'b0, b_i};
        if (dif[SW-1]) d_o = DW'(dif + SW'(Q));
        else           d_o = DW'(dif);
    end
endmodule

// File: rtl/bfly_k2red.sv
module bfly_k2red #(
    parameter int DW = 12,
    parameter int Q  = 3329,
    parameter int K  = 13,
    parameter int M  = 8
) (
    input  logic [2*DW-1:0] c_i,
    output logic [DW-1:0]   r_o
);
    // Two folds: each maps hi*2^M + lo to K*lo - hi, i.e. multiplies by K mod Q.
    localparam int PW = 2 * DW;
    localparam int CW = PW - M + 2;
    localparam int HW = CW - M;
    localparam int RW = DW + 2;

    logic signed [CW-1:0] fold1;
    logic signed [RW-1:0] hi2;
    logic signed [RW-1:0] fold2;

    always_comb begin
        fold1 = $signed(CW'(c_i[M-1:0]) * CW'(K) - CW'(c_i[PW-1:M]));
        hi2   = {{(RW-HW){fold1[CW-1]}}, fold1[CW-1:M]};
        fold2 = $signed(RW'(fold1[M-1:0]) * RW'(K)) - hi2;
        if (fold2[RW-1])
            r_o = DW'($unsigned(fold2) + RW'(Q));
        else if ($unsigned(fold2) >= RW'(Q))
            r_o = DW'($unsigned(fold2) - RW'(Q));
        else
            r_o = DW'($unsigned(fold2));
    end
endmodule

// File: rtl/bfly_core.sv
module bfly_core
    import bfly_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic [1:0]    mode_i,
    input  logic [DW-1:0] u_i,
    input  logic [DW-1:0] v_i,
    input  logic [DW-1:0] w_i,
    output logic          valid_o,
    output logic [DW-1:0] x_o,
    output logic [DW-1:0] y_o
);
    localparam longint KSQ = longint'(KF) * longint'(KF);

    pipe_t pipe_d, pipe_q;
    coef_t gs_diff_d;
    coef_t red_d;
    coef_t add_b_d;
    coef_t sum_d;
    coef_t dif_d;

    // Inverse role subtracts before the multiplier.
    bfly_modsub #(.DW(DW), .Q(Q)) u_pre_sub (
        .a_i(v_i), .b_i(u_i), .d_o(gs_diff_d)
    );

    bfly_k2red #(.DW(DW), .Q(Q), .K(KF), .M(MS)) u_red (
        .c_i(pipe_q.s2.prod), .r_o(red_d)
    );

    // One adder at the tail: forward adds the product, inverse adds the delayed v.
    assign add_b_d = (pipe_q.s3.mode == BF_GS) ? pipe_q.s3.v : pipe_q.s3.t;

    bfly_modadd #(.DW(DW), .Q(Q)) u_post_add (
        .a_i(pipe_q.s3.u), .b_i(add_b_d), .s_o(sum_d)
    );

    bfly_modsub #(.DW(DW), .Q(Q)) u_post_sub (
        .a_i(pipe_q.s3.u), .b_i(pipe_q.s3.t), .d_o(dif_d)
    );

    always_comb begin
        pipe_d = pipe_q;

        pipe_d.s1.vld  = valid_i;
        pipe_d.s1.mode = bf_mode_e'(mode_i);
        pipe_d.s1.u    = u_i;
        pipe_d.s1.v    = v_i;
        pipe_d.s1.w    = w_i;
        pipe_d.s1.op   = (bf_mode_e'(mode_i) == BF_GS) ? gs_diff_d : v_i;

        pipe_d.s2.vld  = pipe_q.s1.vld;
        pipe_d.s2.mode = pipe_q.s1.mode;
        pipe_d.s2.u    = pipe_q.s1.u;
        pipe_d.s2.v    = pipe_q.s1.v;
        pipe_d.s2.prod = PW'(pipe_q.s1.op) * PW'(pipe_q.s1.w);

        pipe_d.s3.vld  = pipe_q.s2.vld;
        pipe_d.s3.mode = pipe_q.s2.mode;
        pipe_d.s3.u    = pipe_q.s2.u;
        pipe_d.s3.v    = pipe_q.s2.v;
        pipe_d.s3.t    = red_d;

        pipe_d.s4.vld  = pipe_q.s3.vld;
        case (pipe_q.s3.mode)
            BF_CT: begin
                pipe_d.s4.x = sum_d;
                pipe_d.s4.y = dif_d;
            end
            BF_GS: begin
                pipe_d.s4.x = sum_d;
                pipe_d.s4.y = pipe_q.s3.t;
            end
            default: begin
                pipe_d.s4.x = pipe_q.s3.u;
                pipe_d.s4.y = pipe_q.s3.v;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign valid_o = pipe_q.s4.vld;
    assign x_o     = pipe_q.s4.x;
    assign y_o     = pipe_q.s4.y;

    // R5: a result never appears without an accepted operand four cycles earlier
    p_vld_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(valid_i, 4));

    // R6: outputs stay inside the field
    p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (int'(x_o) < Q && int'(y_o) < Q));

    // R1: forward outputs sum to 2u mod q
    p_ct_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(mode_i, 4) == BF_CT) |->
        ((int'(x_o) + int'(y_o)) % Q == (2 * int'($past(u_i, 4))) % Q));

    // R2: inverse upper output is the plain modular sum
    p_gs_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(mode_i, 4) == BF_GS) |->
        (int'(x_o) == (int'($past(u_i, 4)) + int'($past(v_i, 4))) % Q));

    // R3: bypass forwards both operands
    p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(mode_i, 4) == BF_PASS) |->
        (x_o == $past(u_i, 4) && y_o == $past(v_i, 4)));

    // R4: the spare code acts as bypass
    p_alt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(mode_i, 4) == BF_ALT) |->
        (x_o == $past(u_i, 4) && y_o == $past(v_i, 4)));

    // R8: the reducer output is congruent to 169 times the registered product
    p_red_cong_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.s3.vld |->
        ((longint'(pipe_q.s3.t) + longint'(Q)
          - (KSQ * longint'($past(pipe_q.s2.prod))) % longint'(Q)) % longint'(Q) == 0));
endmodule

// File: tb/bfly_core_tb.sv
module bfly_core_tb;
    import bfly_pkg::*;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_i = 1'b0;
    logic [1:0]    mode_i = 2'd0;
    logic [DW-1:0] u_i = '0, v_i = '0, w_i = '0;
    logic          valid_o;
    logic [DW-1:0] x_o, y_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int cyc    = 0;

    logic          ev [8];
    logic [DW-1:0] ex [8];
    logic [DW-1:0] ey [8];
    string         et [8];

    always #2 clk = ~clk;

    bfly_core u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mode_i(mode_i),
        .u_i(u_i), .v_i(v_i), .w_i(w_i),
        .valid_o(valid_o), .x_o(x_o), .y_o(y_o)
    );

    function automatic logic [2*DW-1:0] ref_bf(input logic [1:0] m,
                                               input logic [DW-1:0] u, v, w);
        longint t, d, x, y;
        case (m)
            2'd0: begin
                t = (169 * longint'(v) * longint'(w)) % Q;
                x = (longint'(u) + t) % Q;
                y = (longint'(u) - t + Q) % Q;
            end
            2'd1: begin
                x = (longint'(u) + longint'(v)) % Q;
                d = (longint'(v) - longint'(u) + Q) % Q;
                y = (169 * d * longint'(w)) % Q;
            end
            default: begin
                x = longint'(u);
                y = longint'(v);
            end
        endcase
        return {DW'(x), DW'(y)};
    endfunction

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, got, exp, cyc);
        end
    endtask

    task automatic step(input logic vld, input logic [1:0] m,
                        input logic [DW-1:0] u, v, w);
        int s;
        logic [2*DW-1:0] r;
        @(negedge clk);
        s = (cyc + 4) % 8;
        check("R5", "valid_o", int'(valid_o), int'(ev[s]));
        if (ev[s]) begin
            check(et[s], "x_o", int'(x_o), int'(ex[s]));
            check(et[s], "y_o", int'(y_o), int'(ey[s]));
            check("R6", "range", int'(int'(x_o) < Q && int'(y_o) < Q), 1);
        end
        valid_i = vld;
        mode_i  = m;
        u_i     = u;
        v_i     = v;
        w_i     = w;
        r = ref_bf(m, u, v, w);
        s = cyc % 8;
        ev[s] = vld;
        ex[s] = r[2*DW-1:DW];
        ey[s] = r[DW-1:0];
        case (m)
            2'd0:    et[s] = (int'(w) >= Q) ? "R8" : "R1";
            2'd1:    et[s] = (int'(w) >= Q) ? "R8" : "R2";
            2'd2:    et[s] = "R3";
            default: et[s] = "R4";
        endcase
        cyc++;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7331));
        for (int i = 0; i < 8; i++) begin
            ev[i] = 1'b0; ex[i] = '0; ey[i] = '0; et[i] = "R5";
        end
        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7", "valid_o in reset", int'(valid_o), 0);
        check("R7", "x_o in reset", int'(x_o), 0);
        check("R7", "y_o in reset", int'(y_o), 0);
        rst_n = 1'b1;

        // Directed corners for R1, R2, R3, R4, R8
        step(1'b1, 2'd0, 12'd0,    12'd0,    12'd0);
        step(1'b1, 2'd0, 12'd3328, 12'd3328, 12'd3328);
        step(1'b1, 2'd1, 12'd3328, 12'd3328, 12'd3328);
        step(1'b1, 2'd1, 12'd0,    12'd3328, 12'd1);
        step(1'b1, 2'd1, 12'd3328, 12'd0,    12'd1);
        step(1'b1, 2'd0, 12'd5,    12'd0,    12'd4095);
        step(1'b1, 2'd0, 12'd0,    12'd3328, 12'd4095);
        step(1'b1, 2'd1, 12'd1,    12'd2,    12'd4095);
        step(1'b1, 2'd2, 12'd3328, 12'd1234, 12'd4095);
        step(1'b1, 2'd3, 12'd17,   12'd3000, 12'd999);
        step(1'b0, 2'd0, 12'd1,    12'd1,    12'd1);
        step(1'b1, 2'd0, 12'd100,  12'd200,  12'd300);
        step(1'b1, 2'd1, 12'd100,  12'd200,  12'd300);
        step(1'b1, 2'd2, 12'd100,  12'd200,  12'd300);

        // Random mix: mode changes every cycle, gaps in valid_i, wide twiddles
        for (int i = 0; i < 4000; i++) begin
            logic [DW-1:0] w;
            if ($urandom_range(3, 0) == 0) w = DW'($urandom_range(4095, 0));
            else                           w = DW'($urandom_range(Q - 1, 0));
            step(($urandom_range(7, 0) != 0), 2'($urandom_range(3, 0)),
                 DW'($urandom_range(Q - 1, 0)), DW'($urandom_range(Q - 1, 0)), w);
        end

        for (int i = 0; i < 6; i++) step(1'b0, 2'd0, '0, '0, '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule